// File: doc/BRIEF.md
# Critical-Word-First Cache Line Refill Sequencer

This block refills one cache line from external memory after a read miss. It takes a request that carries the missed byte address and the way chosen for replacement. It then issues a single memory read for the 8-byte beat that holds the missed address and accepts the four beats of the line in wrapping order. The critical beat comes first. Each beat that arrives is written straight into the proper quad-word slot of the data array. The first beat is also forwarded to the requester on an early-return strobe in the same cycle, so the pipeline can restart while the other three beats are still arriving.

Once the last beat has been written, a one-cycle completion pulse presents the tag, set and way of the line, and the cache then commits its tag, valid, dirty and replacement state. The block takes no new request until the fill ends. While the fill runs, it tells lookups to the line being filled whether the quad-word they want is already in the array or whether they must stall.

Top module: `linefill_seq`

## Requirements
- R1: `req_ready` is high only while no fill is running. A request is taken in a cycle where `req_valid` and `req_ready` are both high. `busy` is high from the cycle after that until the cycle in which the last beat is written, inclusive.
- R2: In the cycle after a request is taken, `mem_req_valid` rises. It stays high with `mem_req_addr` unchanged until a cycle in which `mem_req_ready` is high. `mem_req_addr` is the missed address with bits [2:0] cleared.
- R3: The start slot is address bits [4:3]. The beat received n-th (n = 0..3) is written to quad-word slot (start + n) mod 4.
- R4: After the memory request is taken, `arr_we` is high in exactly those cycles where `mem_rsp_valid` is high, until the fourth beat. `arr_wdata` equals `mem_rsp_data`. `arr_way` is the requested way. `arr_set` is address bits [12:5].
- R5: `early_valid` is high only in the cycle that writes the first beat, and `early_data` carries that beat.
- R6: `fill_done` pulses for exactly one cycle, the cycle after the fourth beat. In that cycle `done_tag` holds address bits [31:13], `done_set` holds bits [12:5] and `done_way` holds the requested way.
- R7: A `req_valid` that arrives while a fill runs is ignored. The slots, data, tag and set of the running fill are unchanged.
- R8: While a fill runs, a lookup with the same tag and set whose slot (lookup address bits [4:3]) was written in an earlier cycle has `lookup_stall` low. A lookup to a slot not yet written has `lookup_stall` high. A lookup to any other line has `lookup_stall` low.
- R9: `mem_rsp_valid` has no effect (no `arr_we`) while the memory request is still pending or while no fill is running.
- R10: After reset the block is idle: `req_ready` high, and `busy`, `mem_req_valid`, `arr_we`, `early_valid` and `fill_done` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Refill request |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_addr | input | 32 | Missed byte address |
| req_way | input | 2 | Way chosen for replacement |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory took the request |
| mem_req_addr | output | 32 | Address of the critical beat (bits [2:0] zero) |
| mem_rsp_valid | input | 1 | Beat present on mem_rsp_data |
| mem_rsp_data | input | 64 | Beat data |
| arr_we | output | 1 | Data-array write enable |
| arr_way | output | 2 | Way written |
| arr_set | output | 8 | Set written |
| arr_slot | output | 2 | Quad-word slot written |
| arr_wdata | output | 64 | Data written |
| early_valid | output | 1 | Critical beat returned to requester |
| early_data | output | 64 | Critical beat data |
| busy | output | 1 | Fill running |
| fill_done | output | 1 | Line complete, commit tag state |
| done_tag | output | 19 | Tag of the filled line |
| done_set | output | 8 | Set of the filled line |
| done_way | output | 2 | Way of the filled line |
| lookup_valid | input | 1 | Lookup probe present |
| lookup_addr | input | 32 | Lookup byte address |
| lookup_stall | output | 1 | Lookup must wait for its beat |

## Verification
The memory request appears one cycle after the request is taken. Array writes and the early-return strobe are combinational from a response beat, so they are due in the same cycle as that beat. The completion pulse and the release of `busy` come one cycle after the fourth beat. The stall answer for a slot changes one cycle after that slot's beat. The bench drives every input on the falling edge and samples one nanosecond later, inside the same cycle. A scoreboard pops one expected slot and data word for each write it sees, and arms the completion check for the following sample.

// File: rtl/lf_pkg.sv
package lf_pkg;

    typedef enum logic [1:0] {
        FS_IDLE = 2'd0,
        FS_REQ  = 2'd1,
        FS_DATA = 2'd2
    } fill_state_e;

    // Slot reached after stepping forward from a start slot, wrapping at the line end
    function automatic int unsigned wrap_slot(input int unsigned first,
                                              input int unsigned step,
                                              input int unsigned beats);
        return (first + step) % beats;
    endfunction

endpackage

// File: rtl/lf_ctrl.sv
module lf_ctrl
    import lf_pkg::*;
#(
    parameter int BEATS = 4,
    localparam int CNT_W = (BEATS > 1) ? $clog2(BEATS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_req,
    input  logic             mem_ready,
    input  logic             rsp_valid,
    output logic             idle,
    output logic             accept,
    output logic             issuing,
    output logic             beat_we,
    output logic [CNT_W-1:0] beat_idx,
    output logic             first_beat,
    output logic             last_beat,
    output logic             done_pulse
);
    fill_state_e      state_q;
    logic [CNT_W-1:0] beat_q;
    logic             done_q;

    assign idle       = (state_q == FS_IDLE);
    assign accept     = idle && start_req;
    assign issuing    = (state_q == FS_REQ);
    assign beat_we    = (state_q == FS_DATA) && rsp_valid;
    assign beat_idx   = beat_q;
    assign first_beat = beat_we && (beat_q == '0);
    assign last_beat  = beat_we && (beat_q == CNT_W'(BEATS - 1));
    assign done_pulse = done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= FS_IDLE;
            beat_q  <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= last_beat;
            case (state_q)
                FS_IDLE: begin
                    if (start_req) begin
                        state_q <= FS_REQ;
                        beat_q  <= '0;
                    end
                end
                FS_REQ: begin
                    if (mem_ready) state_q <= FS_DATA;
                end
                FS_DATA: begin
                    if (rsp_valid) begin
                        if (beat_q == CNT_W'(BEATS - 1)) begin
                            state_q <= FS_IDLE;
                            beat_q  <= '0;
                        end else begin
                            beat_q <= beat_q + 1'b1;
                        end
                    end
                end
                default: state_q <= FS_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/lf_order.sv
module lf_order
    import lf_pkg::*;
#(
    parameter int BEATS = 4,
    localparam int SLOT_W = (BEATS > 1) ? $clog2(BEATS) : 1
) (
    input  logic [SLOT_W-1:0] first_slot,
    input  logic [SLOT_W-1:0] step,
    output logic [SLOT_W-1:0] slot
);
    generate
        if ((BEATS & (BEATS - 1)) == 0) begin : g_pow2
            // Power-of-two line: the adder wraps by itself
            assign slot = first_slot + step;
        end else begin : g_mod
            always_comb begin
                slot = SLOT_W'(wrap_slot(int'(first_slot), int'(step), BEATS));
            end
        end
    endgenerate
endmodule

// File: rtl/lf_track.sv
module lf_track #(
    parameter int BEATS = 4,
    localparam int SLOT_W = (BEATS > 1) ? $clog2(BEATS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              mark,
    input  logic [SLOT_W-1:0] mark_slot,
    input  logic [SLOT_W-1:0] query_slot,
    output logic              query_present
);
    logic [BEATS-1:0] present_q;

    generate
        for (genvar s = 0; s < BEATS; s++) begin : g_slot
            always_ff @(posedge clk) begin
                if (rst || clear) begin
                    present_q[s] <= 1'b0;
                end else if (mark && (mark_slot == SLOT_W'(s))) begin
                    present_q[s] <= 1'b1;
                end
            end
        end
    endgenerate

    assign query_present = present_q[query_slot];
endmodule

// File: rtl/linefill_seq.sv
module linefill_seq
    import lf_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int LINE_BYTES  = 32,
    parameter int BEAT_BYTES  = 8,
    parameter int SET_W       = 8,
    parameter int WAY_W       = 2,
    localparam int BEATS      = LINE_BYTES / BEAT_BYTES,
    localparam int DATA_W     = BEAT_BYTES * 8,
    localparam int SLOT_W     = (BEATS > 1) ? $clog2(BEATS) : 1,
    localparam int BOFF_W     = $clog2(BEAT_BYTES),
    localparam int LOFF_W     = $clog2(LINE_BYTES),
    localparam int TAG_W      = ADDR_W - LOFF_W - SET_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [WAY_W-1:0]  req_way,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_data,
    output logic              arr_we,
    output logic [WAY_W-1:0]  arr_way,
    output logic [SET_W-1:0]  arr_set,
    output logic [SLOT_W-1:0] arr_slot,
    output logic [DATA_W-1:0] arr_wdata,
    output logic              early_valid,
    output logic [DATA_W-1:0] early_data,
    output logic              busy,
    output logic              fill_done,
    output logic [TAG_W-1:0]  done_tag,
    output logic [SET_W-1:0]  done_set,
    output logic [WAY_W-1:0]  done_way,
    input  logic              lookup_valid,
    input  logic [ADDR_W-1:0] lookup_addr,
    output logic              lookup_stall
);
    typedef struct packed {
        logic [TAG_W-1:0]  tag;
        logic [SET_W-1:0]  set;
        logic [SLOT_W-1:0] start;
        logic [WAY_W-1:0]  way;
    } line_info_t;

    line_info_t       line_q;
    logic             idle, accept, issuing, beat_we, first_beat, last_beat, done_pulse;
    logic [SLOT_W-1:0] beat_idx;
    logic [SLOT_W-1:0] cur_slot;
    logic [TAG_W-1:0]  lk_tag;
    logic [SET_W-1:0]  lk_set;
    logic [SLOT_W-1:0] lk_slot;
    logic              lk_present;
    logic              lk_same_line;

    lf_ctrl #(.BEATS(BEATS)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start_req  (req_valid),
        .mem_ready  (mem_req_ready),
        .rsp_valid  (mem_rsp_valid),
        .idle       (idle),
        .accept     (accept),
        .issuing    (issuing),
        .beat_we    (beat_we),
        .beat_idx   (beat_idx),
        .first_beat (first_beat),
        .last_beat  (last_beat),
        .done_pulse (done_pulse)
    );

    lf_order #(.BEATS(BEATS)) u_order (
        .first_slot (line_q.start),
        .step       (beat_idx),
        .slot       (cur_slot)
    );

    lf_track #(.BEATS(BEATS)) u_track (
        .clk           (clk),
        .rst           (rst),
        .clear         (accept),
        .mark          (beat_we),
        .mark_slot     (cur_slot),
        .query_slot    (lk_slot),
        .query_present (lk_present)
    );

    // Capture the missed line on acceptance
    always_ff @(posedge clk) begin
        if (rst) begin
            line_q <= '0;
        end else if (accept) begin
            line_q.tag   <= req_addr[ADDR_W-1:LOFF_W+SET_W];
            line_q.set   <= req_addr[LOFF_W+SET_W-1:LOFF_W];
            line_q.start <= req_addr[LOFF_W-1:BOFF_W];
            line_q.way   <= req_way;
        end
    end

    assign req_ready     = idle;
    assign busy          = !idle;
    assign mem_req_valid = issuing;
    assign mem_req_addr  = {line_q.tag, line_q.set, line_q.start, {BOFF_W{1'b0}}};

    assign arr_we    = beat_we;
    assign arr_way   = line_q.way;
    assign arr_set   = line_q.set;
    assign arr_slot  = cur_slot;
    assign arr_wdata = mem_rsp_data;

    assign early_valid = first_beat;
    assign early_data  = mem_rsp_data;

    assign fill_done = done_pulse;
    assign done_tag  = line_q.tag;
    assign done_set  = line_q.set;
    assign done_way  = line_q.way;

    assign lk_tag       = lookup_addr[ADDR_W-1:LOFF_W+SET_W];
    assign lk_set       = lookup_addr[LOFF_W+SET_W-1:LOFF_W];
    assign lk_slot      = lookup_addr[LOFF_W-1:BOFF_W];
    assign lk_same_line = (lk_tag == line_q.tag) && (lk_set == line_q.set);
    assign lookup_stall = lookup_valid && busy && lk_same_line && !lk_present;

endmodule

// File: rtl/lf_checker.sv
module lf_checker #(
    parameter int ADDR_W = 32,
    parameter int BEATS  = 4,
    parameter int BOFF_W = 3,
    parameter int SLOT_W = 2,
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_addr,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic              mem_rsp_valid,
    input logic              arr_we,
    input logic [SLOT_W-1:0] arr_slot,
    input logic [DATA_W-1:0] arr_wdata,
    input logic              early_valid,
    input logic [DATA_W-1:0] early_data,
    input logic              busy,
    input logic              fill_done,
    input logic              lookup_stall
);
    logic [SLOT_W-1:0] start_q;
    logic [SLOT_W-1:0] seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            start_q <= '0;
            seen_q  <= '0;
        end else if (req_valid && req_ready) begin
            start_q <= req_addr[BOFF_W+SLOT_W-1:BOFF_W];
            seen_q  <= '0;
        end else if (arr_we) begin
            seen_q <= seen_q + 1'b1;
        end
    end

    a_r1_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> busy);

    a_r2_request_held: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    a_r3_wrap_slot: assert property (@(posedge clk) disable iff (rst)
        arr_we |-> (arr_slot == SLOT_W'((int'(start_q) + int'(seen_q)) % BEATS)));

    a_r4_write_needs_beat: assert property (@(posedge clk) disable iff (rst)
        arr_we |-> (mem_rsp_valid && busy));

    a_r5_early_is_write: assert property (@(posedge clk) disable iff (rst)
        early_valid |-> (arr_we && early_data == arr_wdata && seen_q == '0));

    a_r6_done_after_write: assert property (@(posedge clk) disable iff (rst)
        fill_done |-> ($past(arr_we) && !busy));

    a_r7_no_take_when_busy: assert property (@(posedge clk) disable iff (rst)
        busy |-> !req_ready);

    a_r8_stall_only_busy: assert property (@(posedge clk) disable iff (rst)
        lookup_stall |-> busy);

    a_r9_no_write_during_request: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> !arr_we);
endmodule

bind linefill_seq lf_checker #(
    .ADDR_W (ADDR_W),
    .BEATS  (BEATS),
    .BOFF_W (BOFF_W),
    .SLOT_W (SLOT_W),
    .DATA_W (DATA_W)
) u_lf_checker (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_addr      (req_addr),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .arr_we        (arr_we),
    .arr_slot      (arr_slot),
    .arr_wdata     (arr_wdata),
    .early_valid   (early_valid),
    .early_data    (early_data),
    .busy          (busy),
    .fill_done     (fill_done),
    .lookup_stall  (lookup_stall)
);

// File: tb/linefill_seq_test.sv
module linefill_seq_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_way = '0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;
    logic        arr_we;
    logic [1:0]  arr_way;
    logic [7:0]  arr_set;
    logic [1:0]  arr_slot;
    logic [63:0] arr_wdata;
    logic        early_valid;
    logic [63:0] early_data;
    logic        busy;
    logic        fill_done;
    logic [18:0] done_tag;
    logic [7:0]  done_set;
    logic [1:0]  done_way;
    logic        lookup_valid = 1'b0;
    logic [31:0] lookup_addr = '0;
    logic        lookup_stall;

    int checks = 0;
    int fails  = 0;

    typedef struct {
        logic [1:0]  slot;
        logic [63:0] data;
        bit          first;
        bit          last;
        logic [18:0] tag;
        logic [7:0]  set;
        logic [1:0]  way;
    } exp_t;

    exp_t exp_q[$];
    bit   done_due = 1'b0;
    exp_t done_exp;

    always #4 clk = ~clk;

    linefill_seq uut (.*);

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] beat_data(input logic [31:0] addr, input logic [1:0] slot);
        return {addr[31:5], 5'b0, 16'hBEA7, 14'h0, slot};
    endfunction

    // Scoreboard monitor
    always begin
        @(negedge clk);
        #1;
        if (done_due) begin
            check(fill_done === 1'b1, "R6", "fill_done", 64'(fill_done), 64'd1);
            check(done_tag == done_exp.tag && done_set == done_exp.set && done_way == done_exp.way,
                  "R6", "done line", {done_tag, done_set, done_way}, {done_exp.tag, done_exp.set, done_exp.way});
            done_due = 1'b0;
        end else if (fill_done) begin
            check(1'b0, "R6", "extra fill_done", 64'd1, 64'd0);
        end
        if (arr_we) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R9", "unexpected arr_we", 64'd1, 64'd0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(arr_slot == e.slot, "R3", "arr_slot", 64'(arr_slot), 64'(e.slot));
                check(arr_wdata == e.data && arr_way == e.way && arr_set == e.set,
                      "R4", "write data", arr_wdata, e.data);
                check(early_valid == e.first, "R5", "early_valid", 64'(early_valid), 64'(e.first));
                if (e.first) check(early_data == e.data, "R5", "early_data", early_data, e.data);
                if (e.last) begin
                    done_due = 1'b1;
                    done_exp = e;
                end
            end
        end else if (early_valid) begin
            check(1'b0, "R5", "early without write", 64'd1, 64'd0);
        end
    end

    // Driver: one complete fill
    task automatic do_fill(input logic [31:0] addr, input logic [1:0] way,
                           input int rdy_delay, input int gap, input bit probe);
        logic [1:0] st;
        st = addr[4:3];
        @(negedge clk);
        #1;
        check(req_ready === 1'b1, "R1", "ready when idle", 64'(req_ready), 64'd1);
        for (int n = 0; n < 4; n++) begin
            exp_t e;
            e.slot  = 2'((int'(st) + n) % 4);
            e.data  = beat_data(addr, e.slot);
            e.first = (n == 0);
            e.last  = (n == 3);
            e.tag   = addr[31:13];
            e.set   = addr[12:5];
            e.way   = way;
            exp_q.push_back(e);
        end
        req_valid = 1'b1;
        req_addr  = addr;
        req_way   = way;
        @(negedge clk);
        // R7: keep a different request asserted while busy
        req_addr  = addr ^ 32'h0001_2340;
        req_way   = ~way;
        mem_rsp_valid = 1'b1;   // R9: beat before memory takes request
        mem_rsp_data  = 64'hDEAD;
        #1;
        check(busy === 1'b1 && req_ready === 1'b0, "R1", "busy after accept", 64'(busy), 64'd1);
        check(mem_req_valid === 1'b1, "R2", "mem_req_valid", 64'(mem_req_valid), 64'd1);
        check(mem_req_addr == {addr[31:3], 3'b0}, "R2", "mem_req_addr", 64'(mem_req_addr), 64'({addr[31:3], 3'b0}));
        check(arr_we === 1'b0, "R9", "no write while requesting", 64'(arr_we), 64'd0);
        for (int d = 0; d < rdy_delay; d++) begin
            @(negedge clk);
            #1;
            check(mem_req_valid === 1'b1 && mem_req_addr == {addr[31:3], 3'b0},
                  "R2", "request held", 64'(mem_req_addr), 64'({addr[31:3], 3'b0}));
        end
        @(negedge clk);
        mem_req_ready = 1'b1;
        mem_rsp_valid = 1'b0;
        @(negedge clk);
        mem_req_ready = 1'b0;
        req_valid = 1'b0;
        for (int n = 0; n < 4; n++) begin
            logic [1:0] sl;
            sl = 2'((int'(st) + n) % 4);
            for (int g = 0; g < gap; g++) begin
                mem_rsp_valid = 1'b0;
                @(negedge clk);
            end
            mem_rsp_valid = 1'b1;
            mem_rsp_data  = beat_data(addr, sl);
            if (probe && n == 2) begin
                lookup_valid = 1'b1;
                lookup_addr  = {addr[31:5], st, 3'b101};
                #1;
                check(lookup_stall === 1'b0, "R8", "written slot served", 64'(lookup_stall), 64'd0);
                lookup_addr  = {addr[31:5], 2'(st + 2'd3), 3'b000};
                #1;
                check(lookup_stall === 1'b1, "R8", "pending slot stalls", 64'(lookup_stall), 64'd1);
                lookup_addr  = {addr[31:5], sl, 3'b000};
                #1;
                check(lookup_stall === 1'b1, "R8", "same-cycle slot stalls", 64'(lookup_stall), 64'd1);
                lookup_addr  = {addr[31:13], addr[12:5] + 8'd1, st, 3'b000};
                #1;
                check(lookup_stall === 1'b0, "R8", "other line", 64'(lookup_stall), 64'd0);
                lookup_valid = 1'b0;
            end
            if (n == 3) begin
                #1;
                check(busy === 1'b1, "R1", "busy on last beat", 64'(busy), 64'd1);
            end
            @(negedge clk);
        end
        mem_rsp_valid = 1'b1;   // R9: beat after fill ends is ignored
        mem_rsp_data  = 64'hBAD;
        #1;
        check(busy === 1'b0 && req_ready === 1'b1, "R1", "idle after fill", 64'(busy), 64'd0);
        check(arr_we === 1'b0, "R9", "no write when idle", 64'(arr_we), 64'd0);
        @(negedge clk);
        mem_rsp_valid = 1'b0;
        check(exp_q.size() == 0, "R7", "all beats consumed", 64'(exp_q.size()), 64'd0);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        check(1'b0, "R1", "watchdog expired", 64'd0, 64'd1);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R10 reset state
        check(req_ready === 1'b1 && busy === 1'b0, "R10", "idle after reset", 64'(busy), 64'd0);
        check(mem_req_valid === 1'b0 && arr_we === 1'b0 && early_valid === 1'b0 && fill_done === 1'b0,
              "R10", "outputs quiet", 64'({mem_req_valid, arr_we, early_valid, fill_done}), 64'd0);
        do_fill(32'h1234_5600, 2'd0, 0, 0, 1'b0);   // start slot 0
        do_fill(32'h89AB_CD78, 2'd3, 2, 0, 1'b1);   // start slot 3, wraps
        do_fill(32'h0000_2F52, 2'd1, 1, 2, 1'b1);   // start slot 2, gaps
        do_fill(32'hFFFF_E0E8, 2'd2, 0, 1, 1'b0);   // start slot 1
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule